// File: doc/BRIEF.md
# Guarded GPIO Pad Configuration Bank

This block holds the pad settings for one eight-pin general-purpose I/O port. For every pin it stores an alternate-function enable, a digital-input enable, a pull-up select, a pull-down select and a four-bit peripheral selector. These settings drive the pad logic directly. Software reads and writes them over a plain memory-mapped bus. Each access uses a word address, a 32-bit write value, a write strobe and a combinational read value.

Some pins are critical, for example the debug port and the non-maskable interrupt input. These pins are guarded so that a stray write cannot take them away. A key register drives a two-state lock machine. Its states are `LK_CLOSED` and `LK_OPEN`. Reset enters `LK_CLOSED`. A write of the key value moves it from `LK_CLOSED` to `LK_OPEN`. A write of any other value moves it from `LK_OPEN` to `LK_CLOSED`. A key write in `LK_OPEN`, or a non-key write in `LK_CLOSED`, leaves the state unchanged. A per-pin commit mask can only be changed in `LK_OPEN`. A write to a guarded pin's bit in any settings register takes effect only while that pin's commit bit is set. The pull-up and pull-down selections of a pin clear each other, so a pin never has both. Each pin has its own reset value.

Top module: `gpcfg_bank`

## Requirements
- R1: After reset the pad outputs and registers take per-pin defaults. Pins 0-3 (debug) reset to alt-function 1, digital enable 1, pull-up 1, pull-down 0 and selector 0x3. Pins 4-5 (serial) reset to alt-function 1, digital enable 1, no pulls and selector 0x1. Pins 6-7 reset to all zero. These give alt-function 0x3F, digital enable 0x3F, pull-up 0x0F, pull-down 0x00 and selector word 0x00113333.
- R2: The lock register at 0x518 reads 1 when locked and 0 when unlocked. Reset locks it. Writing 0xC0DEA5A5 unlocks it, and writing any other value locks it.
- R3: The commit register at 0x51C has guarded pins 0, 1, 2, 3 and 7 (mask 0x8F). Their bits reset to 0, and the bits of pins 4-6 read 1 and never change. A guarded commit bit changes only on a write made while the port is unlocked. Relocking the port leaves the commit bits as they are.
- R4: While pin n's commit bit is 0, writes leave pin n's alt-function (0x500), digital enable (0x504), pull-up (0x510), pull-down (0x514) and selector bits unchanged. Writes to other pins in the same access still take effect.
- R5: While pin n's commit bit is 1, a write to any settings register updates pin n's bit or field with the written value.
- R6: A permitted write of 1 to a pull-up bit also clears the same pin's pull-down bit. A write of 0 to a pull-up bit leaves the pull-down bit alone.
- R7: A permitted write of 1 to a pull-down bit also clears the same pin's pull-up bit, so pull-up and pull-down are never both 1 for any pin.
- R8: The selector register at 0x520 packs pin n's field into bits [4n+3:4n] and is gated by commit bit n. Each register reads back its stored value at its address, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-on or external) |
| bus_addr | input | 12 | Register word address |
| bus_wdata | input | 32 | Write value |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read value for bus_addr |
| pad_afsel | output | 8 | Per-pin alternate-function enable |
| pad_den | output | 8 | Per-pin digital enable |
| pad_pu | output | 8 | Per-pin pull-up select |
| pad_pd | output | 8 | Per-pin pull-down select |
| pad_pctl | output | 32 | Per-pin 4-bit peripheral selector |

## Verification
The guard is tried with all-ones and all-zeros writes to registers that mix guarded and unguarded pins. These show whether the commit mask gates each bit separately or the whole access. Writes to the commit register are made while locked, after a wrong key, after the right key and after relocking. These tell apart a lock that opens on any write, one that never opens, and one that clears commits when it closes. The pull registers get a full-byte pull-down write and then a partial pull-up write. This separates correct cross-clearing from clearing on a written 0. A reset in the middle of the run checks that the per-pin defaults come back.

// File: rtl/gpcfg_pkg.sv
package gpcfg_pkg;

    localparam int        BUS_AW   = 12;
    localparam int        BUS_DW   = 32;

    localparam logic [BUS_AW-1:0] A_ALTFN  = 12'h500;
    localparam logic [BUS_AW-1:0] A_DIGEN  = 12'h504;
    localparam logic [BUS_AW-1:0] A_PULLUP = 12'h510;
    localparam logic [BUS_AW-1:0] A_PULLDN = 12'h514;
    localparam logic [BUS_AW-1:0] A_LOCK   = 12'h518;
    localparam logic [BUS_AW-1:0] A_COMMIT = 12'h51C;
    localparam logic [BUS_AW-1:0] A_PCTL   = 12'h520;

    typedef enum logic {
        LK_CLOSED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_st_e;

endpackage

// File: rtl/gpcfg_lock_fsm.sv
module gpcfg_lock_fsm
    import gpcfg_pkg::*;
#(
    parameter logic [BUS_DW-1:0] KEY = 32'hC0DEA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [BUS_DW-1:0] wdata,
    output logic              unlocked
);

    lock_st_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: if (lock_wr && wdata == KEY) state_d = LK_OPEN;
            LK_OPEN:   if (lock_wr && wdata != KEY) state_d = LK_CLOSED;
            default:   state_d = LK_CLOSED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_OPEN:  unlocked = 1'b1;
            default:  unlocked = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpcfg_commit_reg.sv
module gpcfg_commit_reg #(
    parameter int               NPINS = 8,
    parameter logic [NPINS-1:0] GUARD = 8'h8F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_wr,
    input  logic             unlocked,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] commit
);

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        if (GUARD[i]) begin : g_guarded
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                     bit_q <= 1'b0;
                else if (commit_wr && unlocked) bit_q <= wdata[i];
            end
            assign commit[i] = bit_q;
        end else begin : g_free
            assign commit[i] = 1'b1;
        end
    end

endmodule

// File: rtl/gpcfg_pin.sv
module gpcfg_pin #(
    parameter int                PCTL_W = 4,
    parameter logic              RST_AF = 1'b0,
    parameter logic              RST_DE = 1'b0,
    parameter logic              RST_PU = 1'b0,
    parameter logic              RST_PD = 1'b0,
    parameter logic [PCTL_W-1:0] RST_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              wr_af,
    input  logic              wr_de,
    input  logic              wr_pu,
    input  logic              wr_pd,
    input  logic              wr_pc,
    input  logic              d,
    input  logic [PCTL_W-1:0] d_pc,
    output logic              af,
    output logic              de,
    output logic              pu,
    output logic              pd,
    output logic [PCTL_W-1:0] pc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af <= RST_AF;
            de <= RST_DE;
            pu <= RST_PU;
            pd <= RST_PD;
            pc <= RST_PC;
        end else if (commit) begin
            if (wr_af) af <= d;
            if (wr_de) de <= d;
            if (wr_pc) pc <= d_pc;
            if (wr_pu) begin
                pu <= d;
                if (d) pd <= 1'b0;
            end
            if (wr_pd) begin
                pd <= d;
                if (d) pu <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gpcfg_bank.sv
module gpcfg_bank
    import gpcfg_pkg::*;
#(
    parameter int                       NPINS      = 8,
    parameter int                       PCTL_W     = 4,
    parameter logic [BUS_DW-1:0]        UNLOCK_KEY = 32'hC0DEA5A5,
    parameter logic [NPINS-1:0]         GUARD      = 8'h8F,
    parameter logic [NPINS-1:0]         RST_AF     = 8'h3F,
    parameter logic [NPINS-1:0]         RST_DE     = 8'h3F,
    parameter logic [NPINS-1:0]         RST_PU     = 8'h0F,
    parameter logic [NPINS-1:0]         RST_PD     = 8'h00,
    parameter logic [NPINS*PCTL_W-1:0]  RST_PC     = 32'h0011_3333
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BUS_AW-1:0]        bus_addr,
    input  logic [BUS_DW-1:0]        bus_wdata,
    input  logic                     bus_we,
    output logic [BUS_DW-1:0]        bus_rdata,
    output logic [NPINS-1:0]         pad_afsel,
    output logic [NPINS-1:0]         pad_den,
    output logic [NPINS-1:0]         pad_pu,
    output logic [NPINS-1:0]         pad_pd,
    output logic [NPINS*PCTL_W-1:0]  pad_pctl
);

    localparam int PC_TOT = NPINS * PCTL_W;

    logic             lock_open;
    logic [NPINS-1:0] commit_q;

    logic wr_af, wr_de, wr_pu, wr_pd, wr_pc, wr_lock, wr_cr;

    always_comb begin
        wr_af   = bus_we && bus_addr == A_ALTFN;
        wr_de   = bus_we && bus_addr == A_DIGEN;
        wr_pu   = bus_we && bus_addr == A_PULLUP;
        wr_pd   = bus_we && bus_addr == A_PULLDN;
        wr_pc   = bus_we && bus_addr == A_PCTL;
        wr_lock = bus_we && bus_addr == A_LOCK;
        wr_cr   = bus_we && bus_addr == A_COMMIT;
    end

    gpcfg_lock_fsm #(.KEY(UNLOCK_KEY)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (wr_lock),
        .wdata    (bus_wdata),
        .unlocked (lock_open)
    );

    gpcfg_commit_reg #(.NPINS(NPINS), .GUARD(GUARD)) commit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_wr (wr_cr),
        .unlocked  (lock_open),
        .wdata     (bus_wdata[NPINS-1:0]),
        .commit    (commit_q)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        gpcfg_pin #(
            .PCTL_W (PCTL_W),
            .RST_AF (RST_AF[n]),
            .RST_DE (RST_DE[n]),
            .RST_PU (RST_PU[n]),
            .RST_PD (RST_PD[n]),
            .RST_PC (RST_PC[n*PCTL_W +: PCTL_W])
        ) pin_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (commit_q[n]),
            .wr_af  (wr_af),
            .wr_de  (wr_de),
            .wr_pu  (wr_pu),
            .wr_pd  (wr_pd),
            .wr_pc  (wr_pc),
            .d      (bus_wdata[n]),
            .d_pc   (bus_wdata[n*PCTL_W +: PCTL_W]),
            .af     (pad_afsel[n]),
            .de     (pad_den[n]),
            .pu     (pad_pu[n]),
            .pd     (pad_pd[n]),
            .pc     (pad_pctl[n*PCTL_W +: PCTL_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_ALTFN:  bus_rdata[NPINS-1:0]  = pad_afsel;
            A_DIGEN:  bus_rdata[NPINS-1:0]  = pad_den;
            A_PULLUP: bus_rdata[NPINS-1:0]  = pad_pu;
            A_PULLDN: bus_rdata[NPINS-1:0]  = pad_pd;
            A_LOCK:   bus_rdata[0]          = ~lock_open;
            A_COMMIT: bus_rdata[NPINS-1:0]  = commit_q;
            A_PCTL:   bus_rdata[PC_TOT-1:0] = pad_pctl;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpcfg_bank_chk.sv
module gpcfg_bank_chk
    import gpcfg_pkg::*;
#(
    parameter int                NPINS = 8,
    parameter logic [BUS_DW-1:0] KEY   = 32'hC0DEA5A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              bus_we,
    input logic [NPINS-1:0]  pad_afsel,
    input logic [NPINS-1:0]  pad_den,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic              lock_open,
    input logic [NPINS-1:0]  commit_q
);

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_LOCK && bus_wdata == KEY) |=> lock_open);

    // R2
    other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_LOCK && bus_wdata != KEY) |=> !lock_open);

    // R3
    commit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_open) |=> $stable(commit_q));

    // R4
    afsel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pad_afsel ^ $past(pad_afsel)) & ~$past(commit_q)) == '0);

    // R4
    den_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pad_den ^ $past(pad_den)) & ~$past(commit_q)) == '0);

    // R4
    pull_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pad_pu ^ $past(pad_pu)) | (pad_pd ^ $past(pad_pd)))
                  & ~$past(commit_q)) == '0);

    // R6
    pu_clears_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PULLUP)
        |=> (pad_pd & $past(bus_wdata[NPINS-1:0] & commit_q)) == '0);

    // R7
    no_both_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

endmodule

bind gpcfg_bank gpcfg_bank_chk #(.NPINS(NPINS), .KEY(UNLOCK_KEY)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .pad_afsel (pad_afsel),
    .pad_den   (pad_den),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .lock_open (lock_open),
    .commit_q  (commit_q)
);

// File: tb/gpcfg_bank_tb_top.sv
module gpcfg_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_afsel, pad_den, pad_pu, pad_pd;
    logic [31:0] pad_pctl;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    bit overlap_seen = 0;

    always #2 clk = ~clk;

    gpcfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_afsel(pad_afsel),
        .pad_den(pad_den), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_pctl(pad_pctl)
    );

    localparam logic [11:0] AF = 12'h500, DE = 12'h504, PU = 12'h510, PD = 12'h514;
    localparam logic [11:0] LK = 12'h518, CR = 12'h51C, PC = 12'h520;
    localparam logic [31:0] KEY = 32'hC0DEA5A5;

    // {write, addr, data-or-expected, requirement number}
    localparam int NV = 34;
    localparam logic [48:0] VEC [NV] = '{
        {1'b0, AF, 32'h3F, 4'd1},          // R1
        {1'b0, DE, 32'h3F, 4'd1},
        {1'b0, PU, 32'h0F, 4'd1},
        {1'b0, PD, 32'h00, 4'd1},
        {1'b0, PC, 32'h0011_3333, 4'd1},
        {1'b0, LK, 32'h1, 4'd2},           // R2 locked after reset
        {1'b0, CR, 32'h70, 4'd3},          // R3 reset commit
        {1'b1, AF, 32'h00, 4'd4},
        {1'b0, AF, 32'h0F, 4'd4},          // R4 guarded bits kept
        {1'b1, CR, 32'hFF, 4'd3},
        {1'b0, CR, 32'h70, 4'd3},          // R3 locked commit write ignored
        {1'b1, LK, 32'h1234_5678, 4'd2},
        {1'b0, LK, 32'h1, 4'd2},           // R2 wrong key
        {1'b1, LK, KEY, 4'd2},
        {1'b0, LK, 32'h0, 4'd2},           // R2 right key
        {1'b1, CR, 32'h81, 4'd3},
        {1'b0, CR, 32'hF1, 4'd3},          // R3 unlocked commit write
        {1'b1, PC, 32'hFFFF_FFFF, 4'd8},
        {1'b0, PC, 32'hFFFF_333F, 4'd8},   // R8 nibble gating
        {1'b1, AF, 32'hFF, 4'd5},
        {1'b0, AF, 32'hFF, 4'd5},          // R5 committed write
        {1'b1, PD, 32'hFF, 4'd7},
        {1'b0, PD, 32'hF1, 4'd7},          // R7
        {1'b0, PU, 32'h0E, 4'd7},          // R7 pull-up cleared
        {1'b1, PU, 32'h03, 4'd6},
        {1'b0, PU, 32'h0F, 4'd6},          // R6
        {1'b0, PD, 32'hF0, 4'd6},          // R6 pull-down cleared
        {1'b1, LK, 32'h0, 4'd2},
        {1'b1, CR, 32'h00, 4'd3},
        {1'b0, CR, 32'hF1, 4'd3},          // R3 relock keeps commits
        {1'b0, LK, 32'h1, 4'd2},
        {1'b1, DE, 32'h00, 4'd4},
        {1'b0, DE, 32'h0E, 4'd4},          // R4 after relock
        {1'b0, 12'h600, 32'h0, 4'd8}       // R8 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    always @(negedge clk) if (rst_n && (pad_pu & pad_pd) != 8'h00) overlap_seen = 1'b1;

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][48]) bus_write(VEC[i][47:36], VEC[i][35:4]);
            else begin
                bus_read(VEC[i][47:36], rv);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rv, VEC[i][35:4]);
            end
        end

        // R8 pads follow stored selector value
        check("R8 pad_pctl", pad_pctl, 32'hFFFF_333F);
        // R7 never both pulls
        check("R7 overlap", {31'b0, overlap_seen}, 32'h0);

        // R1 reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 pad_afsel", {24'b0, pad_afsel}, 32'h3F);
        check("R1 pad_den",   {24'b0, pad_den},   32'h3F);
        check("R1 pad_pu",    {24'b0, pad_pu},    32'h0F);
        check("R1 pad_pd",    {24'b0, pad_pd},    32'h00);
        check("R1 pad_pctl",  pad_pctl,           32'h0011_3333);
        bus_read(LK, rv); check("R2 lock after reset", rv, 32'h1);
        bus_read(CR, rv); check("R3 commit after reset", rv, 32'h70);

        // R4 selector write while locked, fresh commit mask
        bus_write(PC, 32'h0);
        bus_read(PC, rv); check("R4 selector guarded", rv, 32'h0000_3333);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule